// File: doc/BRIEF.md
# Slot-Rotated Shared Interrupt Router

The block gathers level-sensitive interrupt requests from up to 64 devices and presents them to a host interrupt controller as a vector of host inputs. Each device has four request pins. A pin is rotated by the device's slot number onto one of four shared interrupt lines, so devices in neighbouring slots spread their first pin across different lines. The block keeps one level bit per device on every shared line. A shared line is active while any of its device bits is set.

Each shared line has a byte-wide route register that selects the host input it drives. A route value outside the host input range disconnects the line. A byte-addressed trigger-mode register, one bit per host input, is exported so that the interrupt controller can treat routed inputs as level-triggered. A lookup port gives configuration software the host input that a device's interrupt pin reaches through the current routes. Software writes that value into the device's own line register.

Top module: `pirq_router`

## Requirements
- R1: A request with slot s and pin p (0..3 standing for the first to fourth pin) changes the level bit of that device on shared line (p + s) mod 4. That line is used as the index into the route registers (0..3 at route offsets 0x60..0x63).
- R2: A request changes only the addressed device's bit on that single line. Other devices' bits on the same line, and every bit on the other lines, keep their values.
- R3: A shared line is active while at least one device bit on it is 1. It stays active until the last of those bits is cleared. A host output is 0 when no line routed to it is active.
- R4: Route registers reset to 0x80 and read back through cfg_rdata_o at offsets 0x60 + line. A write at such an offset replaces the whole byte.
- R5: A route value of HOST_N (16) or more forwards the line to no host output.
- R6: When two or more active lines route to the same host input, that output is 1. It stays 1 until all of those lines are inactive or rerouted.
- R7: host_irq_o depends only on state captured at the clock edge. A request or route write that is applied before an edge shows on the output after that edge and not before.
- R8: Trigger-mode bits reset to 0 and sit at byte offsets 0x68 (host inputs 0..7, bit n = input n) and 0x69 (inputs 8..15). They are writable, read back, and driven on trig_level_o.
- R9: For a lookup pin code of 0, or of more than 4, lkp_valid_o is 0 and lkp_line_o is 0. For a code c of 1..4 with slot s, lkp_valid_o is 1 and lkp_line_o equals the route register of line (c - 1 + s) mod 4.
- R10: A configuration write to any other offset changes no route, no trigger bit and no output. A read of an unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request level update strobe |
| req_dev_i | input | 6 | Device index |
| req_slot_i | input | 5 | Slot number of the device |
| req_pin_i | input | 2 | Pin 0..3 of the device |
| req_level_i | input | 1 | New level for that pin |
| cfg_we_i | input | 1 | Configuration byte write |
| cfg_addr_i | input | 8 | Configuration byte offset |
| cfg_wdata_i | input | 8 | Write data |
| cfg_rdata_o | output | 8 | Read data for cfg_addr_i (combinational) |
| lkp_slot_i | input | 5 | Lookup slot |
| lkp_pin_i | input | 8 | Lookup pin code (0 none, 1..4) |
| lkp_line_o | output | 8 | Route value for the lookup |
| lkp_valid_o | output | 1 | Lookup pin code is in range |
| host_irq_o | output | 16 | Host interrupt levels |
| trig_level_o | output | 16 | Trigger-mode bits, 1 = level |

## Verification
The bench builds the block with its defaults: 64 devices, 5-bit slots and 16 host inputs. With these values the highest device index (63) and a slot of 31 are reachable, and that slot exercises the modulo-4 wrap of the rotation. Route values of exactly 16 and of 0xFF are reachable, so both the first disabled value and the widest one are tried. Two lines are routed onto one host input, so the OR across lines is observed alongside the OR across devices.

// File: rtl/pirq_router_pkg.sv
package pirq_router_pkg;
  localparam int LINE_N = 4;
  typedef logic [1:0] line_t;

  // pin rotated by the low slot bits onto the shared lines
  function automatic line_t swizzle(input logic [1:0] slot_lsb, input logic [1:0] pin);
    return line_t'(pin + slot_lsb);
  endfunction
endpackage

// File: rtl/pirq_level_store.sv
module pirq_level_store
  import pirq_router_pkg::*;
#(
  parameter int NUM_DEV = 64,
  localparam int DEV_W = $clog2(NUM_DEV)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [DEV_W-1:0]  req_dev_i,
  input  line_t             req_line_i,
  input  logic              req_level_i,
  output logic [LINE_N-1:0] line_level_o
);
  logic [LINE_N-1:0][NUM_DEV-1:0] vec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vec_q <= '0;
    else if (req_valid_i && (32'(req_dev_i) < NUM_DEV))
      vec_q[req_line_i][req_dev_i] <= req_level_i;
  end

  for (genvar p = 0; p < LINE_N; p++) begin : g_line
    assign line_level_o[p] = |vec_q[p];

    assert_hold_line_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && req_line_i != line_t'(p)) |=> $stable(vec_q[p]));
  end

  assert_set_bit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> vec_q[$past(req_line_i)][$past(req_dev_i)] == $past(req_level_i));
endmodule

// File: rtl/pirq_cfg_regs.sv
module pirq_cfg_regs
  import pirq_router_pkg::*;
#(
  parameter int HOST_N     = 16,
  parameter int ROUTE_BASE = 'h60,
  parameter int TRIG_BASE  = 'h68,
  localparam int TRIG_BYTES = HOST_N / 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_we_i,
  input  logic [7:0]              cfg_addr_i,
  input  logic [7:0]              cfg_wdata_i,
  output logic [7:0]              cfg_rdata_o,
  output logic [LINE_N-1:0][7:0]  route_o,
  output logic [HOST_N-1:0]       trig_o
);
  logic [LINE_N-1:0][7:0]     route_q;
  logic [TRIG_BYTES-1:0][7:0] trig_q;

  for (genvar p = 0; p < LINE_N; p++) begin : g_route
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) route_q[p] <= 8'h80;
      else if (cfg_we_i && cfg_addr_i == 8'(ROUTE_BASE + p)) route_q[p] <= cfg_wdata_i;
    end

    assert_route_wr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_we_i && cfg_addr_i == 8'(ROUTE_BASE + p)) |=> route_q[p] == $past(cfg_wdata_i));
  end

  for (genvar b = 0; b < TRIG_BYTES; b++) begin : g_trig
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) trig_q[b] <= '0;
      else if (cfg_we_i && cfg_addr_i == 8'(TRIG_BASE + b)) trig_q[b] <= cfg_wdata_i;
    end

    assert_trig_wr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_we_i && cfg_addr_i == 8'(TRIG_BASE + b)) |=> trig_q[b] == $past(cfg_wdata_i));
  end

  always_comb begin
    cfg_rdata_o = '0;
    for (int p = 0; p < LINE_N; p++)
      if (cfg_addr_i == 8'(ROUTE_BASE + p)) cfg_rdata_o = route_q[p];
    for (int b = 0; b < TRIG_BYTES; b++)
      if (cfg_addr_i == 8'(TRIG_BASE + b)) cfg_rdata_o = trig_q[b];
  end

  assign route_o = route_q;
  assign trig_o  = trig_q;
endmodule

// File: rtl/pirq_steer.sv
module pirq_steer
  import pirq_router_pkg::*;
#(
  parameter int HOST_N = 16
) (
  input  logic [LINE_N-1:0]      line_level_i,
  input  logic [LINE_N-1:0][7:0] route_i,
  output logic [HOST_N-1:0]      host_o
);
  // out-of-range route values match no host input
  always_comb begin
    host_o = '0;
    for (int h = 0; h < HOST_N; h++)
      for (int p = 0; p < LINE_N; p++)
        if (line_level_i[p] && route_i[p] == 8'(h)) host_o[h] = 1'b1;
  end
endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_router_pkg::*;
#(
  parameter int NUM_DEV    = 64,
  parameter int SLOT_W     = 5,
  parameter int HOST_N     = 16,
  parameter int ROUTE_BASE = 'h60,
  parameter int TRIG_BASE  = 'h68,
  localparam int DEV_W = $clog2(NUM_DEV)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [DEV_W-1:0]  req_dev_i,
  input  logic [SLOT_W-1:0] req_slot_i,
  input  logic [1:0]        req_pin_i,
  input  logic              req_level_i,
  input  logic              cfg_we_i,
  input  logic [7:0]        cfg_addr_i,
  input  logic [7:0]        cfg_wdata_i,
  output logic [7:0]        cfg_rdata_o,
  input  logic [SLOT_W-1:0] lkp_slot_i,
  input  logic [7:0]        lkp_pin_i,
  output logic [7:0]        lkp_line_o,
  output logic              lkp_valid_o,
  output logic [HOST_N-1:0] host_irq_o,
  output logic [HOST_N-1:0] trig_level_o
);
  logic [LINE_N-1:0]      line_level;
  logic [LINE_N-1:0][7:0] route;
  line_t                  req_line;

  assign req_line = swizzle(req_slot_i[1:0], req_pin_i);

  pirq_level_store #(.NUM_DEV(NUM_DEV)) u_store (
    .clk_i, .rst_ni, .req_valid_i, .req_dev_i,
    .req_line_i(req_line), .req_level_i, .line_level_o(line_level)
  );

  pirq_cfg_regs #(.HOST_N(HOST_N), .ROUTE_BASE(ROUTE_BASE), .TRIG_BASE(TRIG_BASE)) u_cfg (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i, .cfg_rdata_o,
    .route_o(route), .trig_o(trig_level_o)
  );

  pirq_steer #(.HOST_N(HOST_N)) u_steer (
    .line_level_i(line_level), .route_i(route), .host_o(host_irq_o)
  );

  always_comb begin
    lkp_valid_o = 1'b0;
    lkp_line_o  = '0;
    if (lkp_pin_i >= 8'd1 && lkp_pin_i <= 8'd4) begin
      lkp_valid_o = 1'b1;
      lkp_line_o  = route[swizzle(lkp_slot_i[1:0], 2'(lkp_pin_i - 8'd1))];
    end
  end

  assert_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_level == '0) |-> (host_irq_o == '0));

  assert_lookup_none_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_pin_i == 8'd0) |-> !lkp_valid_o);
endmodule

// File: tb/sim_pirq_router.sv
module sim_pirq_router;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_ni = 0;
  logic req_valid = 0, req_level = 0;
  logic [5:0] req_dev = 0;
  logic [4:0] req_slot = 0, lkp_slot = 0;
  logic [1:0] req_pin = 0;
  logic cfg_we = 0;
  logic [7:0] cfg_addr = 0, cfg_wdata = 0, cfg_rdata, lkp_pin = 0, lkp_line;
  logic lkp_valid;
  logic [15:0] host_irq, trig_level;

  int n_chk = 0, n_fail = 0;
  logic [63:0] ref_vec [4];
  logic [7:0]  ref_route [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  pirq_router u0 (
    .clk_i(clk), .rst_ni, .req_valid_i(req_valid), .req_dev_i(req_dev),
    .req_slot_i(req_slot), .req_pin_i(req_pin), .req_level_i(req_level),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .lkp_slot_i(lkp_slot), .lkp_pin_i(lkp_pin),
    .lkp_line_o(lkp_line), .lkp_valid_o(lkp_valid),
    .host_irq_o(host_irq), .trig_level_o(trig_level)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_host();
    logic [15:0] e = '0;
    for (int p = 0; p < 4; p++)
      if (ref_vec[p] != 0 && ref_route[p] < 16) e[ref_route[p][3:0]] = 1'b1;
    return e;
  endfunction

  task automatic dev_req(int dev, int slot, int pin, bit lvl);
    @(negedge clk);
    req_valid = 1; req_dev = 6'(dev); req_slot = 5'(slot); req_pin = 2'(pin); req_level = lvl;
    ref_vec[(pin + slot) % 4][dev] = lvl;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic cfg_wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    if (a >= 8'h60 && a <= 8'h63) ref_route[a - 8'h60] = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic cfg_rd(logic [7:0] a, logic [7:0] exp, string tag);
    cfg_addr = a; #1;
    chk(tag, cfg_rdata, exp);
  endtask

  task automatic t_reset();
    chk("R3 reset host", host_irq, 16'h0);
    chk("R8 reset trig", trig_level, 16'h0);
    for (int p = 0; p < 4; p++) cfg_rd(8'(8'h60 + p), 8'h80, "R4 reset route");
    cfg_rd(8'h68, 8'h00, "R8 reset trig lo");
  endtask

  task automatic t_program();
    cfg_wr(8'h60, 8'd11); cfg_wr(8'h61, 8'd9); cfg_wr(8'h62, 8'd11); cfg_wr(8'h63, 8'd9);
    cfg_wr(8'h68, 8'h00); cfg_wr(8'h69, 8'h0A);
    cfg_rd(8'h61, 8'd9, "R4 route readback");
    cfg_rd(8'h69, 8'h0A, "R8 trig hi readback");
    chk("R8 trig out", trig_level, 16'h0A00);
  endtask

  task automatic t_swizzle();
    dev_req(0, 0, 0, 1);
    chk("R1 slot0 pinA", host_irq, 16'h0800);
    dev_req(5, 3, 2, 1);   // (2+3)%4 = line 1 -> 9
    chk("R1 slot3 pinC", host_irq, exp_host());
    chk("R1 both", host_irq, 16'h0A00);
    dev_req(0, 0, 0, 0);
    chk("R2 clear one dev", host_irq, 16'h0200);
  endtask

  task automatic t_shared();
    dev_req(7, 1, 3, 1);    // line 0
    dev_req(63, 31, 1, 1);  // (1+31)%4 = 0
    chk("R3 two devs", host_irq, 16'h0A00);
    dev_req(7, 1, 3, 0);
    chk("R3 one dev left", host_irq, 16'h0A00);
    dev_req(63, 31, 1, 0);
    chk("R3 last cleared", host_irq, 16'h0200);
  endtask

  task automatic t_merge();
    dev_req(10, 2, 0, 1);   // line 2 -> 11
    dev_req(20, 0, 0, 1);   // line 0 -> 11
    chk("R6 two lines", host_irq, 16'h0A00);
    dev_req(20, 0, 0, 0);
    chk("R6 one line left", host_irq, 16'h0A00);
    dev_req(10, 2, 0, 0);
    chk("R6 none left", host_irq, exp_host());
  endtask

  task automatic t_disable();
    dev_req(1, 0, 0, 1);    // line 0 active
    cfg_wr(8'h60, 8'd16);
    chk("R5 route 16", host_irq, 16'h0200);
    cfg_wr(8'h60, 8'hFF);
    chk("R5 route ff", host_irq, 16'h0200);
    cfg_wr(8'h60, 8'd3);
    chk("R5 reroute 3", host_irq, 16'h0208);
  endtask

  task automatic t_timing();
    @(negedge clk);
    req_valid = 1; req_dev = 6'd2; req_slot = 5'd0; req_pin = 2'd0; req_level = 0;
    ref_vec[0][2] = 0;
    #1 chk("R7 before edge", host_irq, 16'h0208);
    @(negedge clk); req_valid = 0;
    chk("R7 after edge", host_irq, 16'h0208);
    dev_req(1, 0, 0, 0);
    chk("R7 drop", host_irq, 16'h0200);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 8'h61; cfg_wdata = 8'd5; ref_route[1] = 8'd5;
    #1 chk("R7 route before edge", host_irq, 16'h0200);
    @(negedge clk); cfg_we = 0;
    chk("R7 route after edge", host_irq, 16'h0020);
  endtask

  task automatic t_lookup();
    lkp_slot = 5'd1; lkp_pin = 8'd0; #1;
    chk("R9 pin0 valid", lkp_valid, 0);
    chk("R9 pin0 line", lkp_line, 0);
    lkp_pin = 8'd5; #1;
    chk("R9 pin5 valid", lkp_valid, 0);
    lkp_pin = 8'd1; #1;     // line 1 -> 5
    chk("R9 valid", lkp_valid, 1);
    chk("R9 line slot1", lkp_line, 8'd5);
    lkp_slot = 5'd31; lkp_pin = 8'd4; #1;  // (3+31)%4 = 2 -> 11
    chk("R9 line slot31", lkp_line, 8'd11);
  endtask

  task automatic t_ignored();
    cfg_wr(8'h64, 8'd0);
    cfg_wr(8'h6A, 8'hFF);
    cfg_wr(8'h5F, 8'd0);
    chk("R10 host unchanged", host_irq, exp_host());
    chk("R10 trig unchanged", trig_level, 16'h0A00);
    for (int p = 0; p < 4; p++) cfg_rd(8'(8'h60 + p), ref_route[p], "R10 route unchanged");
    cfg_rd(8'h64, 8'h00, "R10 unmapped read");
  endtask

  initial begin
    for (int p = 0; p < 4; p++) begin ref_vec[p] = '0; ref_route[p] = 8'h80; end
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1;
    t_program();
    t_swizzle();
    t_shared();
    t_merge();
    t_disable();
    t_timing();
    t_lookup();
    t_ignored();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule